// File: doc/BRIEF.md
# Packed-Pixel Palette Scanout for a VGA Raster

This block turns a small captured picture, held as packed 4-bit colour indices, into pixel-rate colour for a VGA raster. It runs its own horizontal and vertical position counters and fetches picture bytes through the read port of a dual-port RAM. Each byte carries two pixels: the upper nibble is shown first (left) and the lower nibble second. Every source pixel is repeated on two consecutive clocks and on two consecutive lines. A 256x192 picture therefore fills a 512x384 window, and that window is centred inside the active raster.

Each index goes through a 16-entry palette whose entries are 8-bit RRRGGGBB words, so the picture can use any 16 of 256 colours. Index 0 means transparent. A VGA output has no transparency, so index 0 is always shown as black. Outside the window, and while the raster is blanked, the colour output is zero. The read address leaves the block one clock before its data is used, which covers the single-cycle read latency of the RAM.

The phase of each 4-clock byte slot is tracked by a small state machine with five states. S_OUT means the current raster position is outside the window. Inside the window the sequence is S_HI_A (left pixel, first copy), S_HI_B (left pixel, second copy), S_LO_A (right pixel, first copy) and S_LO_B (right pixel, second copy). The transitions are:
- S_OUT to S_HI_A when the next position is the first column of a window line.
- S_HI_A to S_HI_B, S_HI_B to S_LO_A, and S_LO_A to S_LO_B unconditionally.
- S_LO_B to S_HI_A while the next position is still inside the window.
- S_LO_B to S_OUT at the right edge of the window.

Top module: `scan_top`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it falls, `blank` is 1 and `rgb` is 0.
- R2: The raster position starts at (0,0) and advances one pixel per clock. A line is H_TOTAL clocks and a frame is V_TOTAL lines. The outputs after the k-th edge with `rst` low (k >= 2) describe position k-2. `blank` is 1, with `rgb` 0, exactly when the column is >= H_ACTIVE or the line is >= V_ACTIVE.
- R3: The window starts at column X0 = (H_ACTIVE - 2*SRC_W)/2 and line Y0 = (V_ACTIVE - 2*SRC_H)/2. It spans 2*SRC_W columns and 2*SRC_H lines. At active positions outside it, `rgb` is 0 and `blank` is 0.
- R4: While the raster counter is at window position (h,v), `ram_addr` equals ((v-Y0)/2)*(SRC_W/2) + (h-X0)/4. The block expects the byte at that address on `ram_rdata` one clock later.
- R5: Within a byte, bits [7:4] hold the left pixel and bits [3:0] hold the right pixel.
- R6: Each source pixel covers two adjacent columns on two adjacent lines. Source pixel (sx,sy) appears at columns X0+2sx and X0+2sx+1, on lines Y0+2sy and Y0+2sy+1.
- R7: An index n from 1 to 15 is shown as PALETTE entry n, in RRRGGGBB form. The default entries are:
  - 1 black 00000000, 2 medium green 00010000, 3 light green 00111001, 4 dark blue 00000010, 5 light blue 00101011
  - 6 dark red 01000000, 7 cyan 00011111, 8 medium red 01100000, 9 light red 11101001, 10 dark yellow 10010000
  - 11 light yellow 11111101, 12 dark green 00001000, 13 magenta 01100010, 14 gray 10110110, 15 white 11111111
- R8: Index 0 is shown as `rgb` 0 whatever value PALETTE entry 0 holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | VGA pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| ram_addr | output | ADDR_W | Byte address to the frame buffer read port |
| ram_rdata | input | 8 | Byte returned by the RAM one clock after the address |
| rgb | output | 8 | Pixel colour, RRRGGGBB |
| blank | output | 1 | 1 while the current pixel lies outside the active raster |

## Verification
The hardest case to reach from the ports is the two-clock gap between the address leaving the block and the matching colour appearing. An off-by-one in that path only shows as a pixel shifted by one column, and a uniform picture hides it completely. The bench therefore loads byte patterns in which every nibble differs from its neighbours: alternating bright and dark pairs, and a sweep of all sixteen indices. It runs the block with a shrunken raster, so whole frames, including the line and frame wrap, fit in a few hundred clocks. It then compares every output pixel against a position model counted from reset release. The palette entry for index 0 is overridden with a bright value, so that forcing index 0 to black can be seen at the ports.

// File: rtl/scan_pkg.sv
package scan_pkg;

    localparam int PIX_W  = 4;
    localparam int BYTE_W = 8;
    localparam int NCOLR  = 1 << PIX_W;

    typedef enum logic [2:0] {
        S_OUT,
        S_HI_A,
        S_HI_B,
        S_LO_A,
        S_LO_B
    } phase_t;

    function automatic logic [NCOLR-1:0][BYTE_W-1:0] make_palette();
        logic [NCOLR-1:0][BYTE_W-1:0] p;
        p[0]  = 8'b000_000_00;   // transparent
        p[1]  = 8'b000_000_00;   // black
        p[2]  = 8'b000_100_00;   // medium green
        p[3]  = 8'b001_110_01;   // light green
        p[4]  = 8'b000_000_10;   // dark blue
        p[5]  = 8'b001_010_11;   // light blue
        p[6]  = 8'b010_000_00;   // dark red
        p[7]  = 8'b000_111_11;   // cyan
        p[8]  = 8'b011_000_00;   // medium red
        p[9]  = 8'b111_010_01;   // light red
        p[10] = 8'b100_100_00;   // dark yellow
        p[11] = 8'b111_111_01;   // light yellow
        p[12] = 8'b000_010_00;   // dark green
        p[13] = 8'b011_000_10;   // magenta
        p[14] = 8'b101_101_10;   // gray
        p[15] = 8'b111_111_11;   // white
        return p;
    endfunction

    localparam logic [NCOLR-1:0][BYTE_W-1:0] DEF_PALETTE = make_palette();

endpackage

// File: rtl/scan_timing.sv
module scan_timing #(
    parameter int H_ACTIVE = 640,
    parameter int H_TOTAL  = 800,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter int HW       = $clog2(H_TOTAL),
    parameter int VW       = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [HW-1:0] hcnt,
    output logic [VW-1:0] vcnt,
    output logic [HW-1:0] nxt_h,
    output logic [VW-1:0] nxt_v,
    output logic          active
);

    localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_ACT  = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_ACT  = VW'(V_ACTIVE);

    always_comb begin
        if (hcnt == H_LAST) begin
            nxt_h = '0;
            nxt_v = (vcnt == V_LAST) ? '0 : vcnt + 1'b1;
        end else begin
            nxt_h = hcnt + 1'b1;
            nxt_v = vcnt;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt <= '0;
            vcnt <= '0;
        end else begin
            hcnt <= nxt_h;
            vcnt <= nxt_v;
        end
    end

    assign active = (hcnt < H_ACT) && (vcnt < V_ACT);

endmodule

// File: rtl/scan_phase_fsm.sv
module scan_phase_fsm
    import scan_pkg::*;
#(
    parameter int SRC_W  = 256,
    parameter int SRC_H  = 192,
    parameter int X0     = 64,
    parameter int Y0     = 48,
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [HW-1:0]     hcnt,
    input  logic [VW-1:0]     vcnt,
    input  logic [HW-1:0]     nxt_h,
    input  logic [VW-1:0]     nxt_v,
    output phase_t            phase,
    output logic              in_win,
    output logic              sel_hi,
    output logic [ADDR_W-1:0] ram_addr
);

    localparam logic [HW-1:0] WX_LO = HW'(X0);
    localparam logic [HW-1:0] WX_HI = HW'(X0 + 2 * SRC_W);
    localparam logic [VW-1:0] WY_LO = VW'(Y0);
    localparam logic [VW-1:0] WY_HI = VW'(Y0 + 2 * SRC_H);
    localparam logic [ADDR_W-1:0] ROW_BYTES = ADDR_W'(SRC_W / 2);
    localparam bit RST_IN = (X0 == 0) && (Y0 == 0);

    phase_t nxt_phase;
    logic   nxt_in;
    logic [HW-1:0]     hrel;
    logic [VW-1:0]     vrel;
    logic [ADDR_W-1:0] row_a;
    logic [ADDR_W-1:0] col_a;

    assign nxt_in = (nxt_h >= WX_LO) && (nxt_h < WX_HI) &&
                    (nxt_v >= WY_LO) && (nxt_v < WY_HI);

    // state register
    always_ff @(posedge clk) begin
        if (rst) phase <= RST_IN ? S_HI_A : S_OUT;
        else     phase <= nxt_phase;
    end

    // transitions
    always_comb begin
        nxt_phase = phase;
        unique case (phase)
            S_OUT:   nxt_phase = nxt_in ? S_HI_A : S_OUT;
            S_HI_A:  nxt_phase = S_HI_B;
            S_HI_B:  nxt_phase = S_LO_A;
            S_LO_A:  nxt_phase = S_LO_B;
            S_LO_B:  nxt_phase = nxt_in ? S_HI_A : S_OUT;
            default: nxt_phase = S_OUT;
        endcase
    end

    // outputs
    always_comb begin
        hrel     = hcnt - WX_LO;
        vrel     = vcnt - WY_LO;
        row_a    = ADDR_W'(vrel[VW-1:1]);
        col_a    = ADDR_W'(hrel[HW-1:2]);
        in_win   = (phase != S_OUT);
        sel_hi   = (phase == S_HI_A) || (phase == S_HI_B);
        ram_addr = in_win ? (row_a * ROW_BYTES + col_a) : '0;
    end

endmodule

// File: rtl/scan_colour.sv
module scan_colour
    import scan_pkg::*;
#(
    parameter logic [NCOLR-1:0][BYTE_W-1:0] PALETTE = DEF_PALETTE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_win,
    input  logic              sel_hi,
    input  logic              active,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [BYTE_W-1:0] rgb,
    output logic              blank
);

    logic              win_q;
    logic              hi_q;
    logic              act_q;
    logic [PIX_W-1:0]  nib;
    logic [BYTE_W-1:0] colour;

    // stage aligned with RAM read data
    always_ff @(posedge clk) begin
        if (rst) begin
            win_q <= 1'b0;
            hi_q  <= 1'b0;
            act_q <= 1'b0;
        end else begin
            win_q <= in_win;
            hi_q  <= sel_hi;
            act_q <= active;
        end
    end

    always_comb begin
        nib    = hi_q ? ram_rdata[BYTE_W-1:PIX_W] : ram_rdata[PIX_W-1:0];
        colour = (win_q && (nib != '0)) ? PALETTE[nib] : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rgb   <= '0;
            blank <= 1'b1;
        end else begin
            rgb   <= act_q ? colour : '0;
            blank <= ~act_q;
        end
    end

endmodule

// File: rtl/scan_top.sv
module scan_top
    import scan_pkg::*;
#(
    parameter int SRC_W    = 256,
    parameter int SRC_H    = 192,
    parameter int H_ACTIVE = 640,
    parameter int H_TOTAL  = 800,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL  = 525,
    parameter logic [NCOLR-1:0][BYTE_W-1:0] PALETTE = DEF_PALETTE,
    parameter int ADDR_W   = $clog2((SRC_W / 2) * SRC_H)
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] ram_addr,
    input  logic [BYTE_W-1:0] ram_rdata,
    output logic [BYTE_W-1:0] rgb,
    output logic              blank
);

    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);
    localparam int X0 = (H_ACTIVE - 2 * SRC_W) / 2;
    localparam int Y0 = (V_ACTIVE - 2 * SRC_H) / 2;
    localparam int WW = 2 * SRC_W;
    localparam int WH = 2 * SRC_H;

    logic [HW-1:0] hcnt;
    logic [VW-1:0] vcnt;
    logic [HW-1:0] nxt_h;
    logic [VW-1:0] nxt_v;
    logic          active;
    phase_t        phase;
    logic          in_win;
    logic          sel_hi;

    scan_timing #(
        .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL),
        .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL),
        .HW(HW), .VW(VW)
    ) u_timing (
        .clk(clk), .rst(rst),
        .hcnt(hcnt), .vcnt(vcnt),
        .nxt_h(nxt_h), .nxt_v(nxt_v),
        .active(active)
    );

    scan_phase_fsm #(
        .SRC_W(SRC_W), .SRC_H(SRC_H), .X0(X0), .Y0(Y0),
        .HW(HW), .VW(VW), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .hcnt(hcnt), .vcnt(vcnt),
        .nxt_h(nxt_h), .nxt_v(nxt_v),
        .phase(phase), .in_win(in_win), .sel_hi(sel_hi),
        .ram_addr(ram_addr)
    );

    scan_colour #(
        .PALETTE(PALETTE)
    ) u_colour (
        .clk(clk), .rst(rst),
        .in_win(in_win), .sel_hi(sel_hi), .active(active),
        .ram_rdata(ram_rdata),
        .rgb(rgb), .blank(blank)
    );

endmodule

// File: rtl/scan_top_chk.sv
module scan_top_chk
    import scan_pkg::*;
#(
    parameter int HW     = 10,
    parameter int VW     = 10,
    parameter int ADDR_W = 15,
    parameter int X0     = 64,
    parameter int Y0     = 48,
    parameter int WW     = 512,
    parameter int WH     = 384
) (
    input logic              clk,
    input logic              rst,
    input logic [HW-1:0]     hcnt,
    input logic [VW-1:0]     vcnt,
    input phase_t            phase,
    input logic              in_win,
    input logic              sel_hi,
    input logic [ADDR_W-1:0] ram_addr,
    input logic [BYTE_W-1:0] ram_rdata,
    input logic [BYTE_W-1:0] rgb,
    input logic              blank
);

    logic rst_d;
    logic geo_win;

    always_ff @(posedge clk) rst_d <= rst;

    assign geo_win = (int'(hcnt) >= X0) && (int'(hcnt) < X0 + WW) &&
                     (int'(vcnt) >= Y0) && (int'(vcnt) < Y0 + WH);

    always @(posedge clk) begin
        if (rst_d === 1'b1)
            AST_RESET_IDLE: assert (blank && rgb == '0); // R1
    end

    AST_BLANK_DARK: assert property (@(posedge clk) disable iff (rst)
        blank |-> (rgb == '0)); // R2

    AST_PHASE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (phase != S_OUT) == geo_win); // R3

    AST_NO_COLOUR_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        (rgb != '0) |-> $past(in_win, 2)); // R3

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (phase == S_HI_A || phase == S_HI_B || phase == S_LO_A) |=> $stable(ram_addr)); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        (phase == S_LO_B && int'(hcnt) != X0 + WW - 1) |=>
        (ram_addr == $past(ram_addr) + 1'b1)); // R4

    AST_IDX0_BLACK: assert property (@(posedge clk) disable iff (rst)
        ($past(in_win) && (($past(sel_hi) ? ram_rdata[7:4] : ram_rdata[3:0]) == 4'h0))
        |=> (rgb == '0)); // R8

endmodule

bind scan_top scan_top_chk #(
    .HW(HW), .VW(VW), .ADDR_W(ADDR_W),
    .X0(X0), .Y0(Y0), .WW(WW), .WH(WH)
) u_chk (
    .clk(clk), .rst(rst),
    .hcnt(hcnt), .vcnt(vcnt),
    .phase(phase), .in_win(in_win), .sel_hi(sel_hi),
    .ram_addr(ram_addr), .ram_rdata(ram_rdata),
    .rgb(rgb), .blank(blank)
);

// File: tb/scan_top_bench.sv
module scan_top_bench;

    localparam int SW = 8;
    localparam int SH = 4;
    localparam int HA = 24;
    localparam int HT = 30;
    localparam int VA = 12;
    localparam int VT = 14;
    localparam int XO = (HA - 2 * SW) / 2;
    localparam int YO = (VA - 2 * SH) / 2;
    localparam int FRAME = HT * VT;
    localparam int NBYTES = (SW / 2) * SH;
    localparam int AW = $clog2(NBYTES);

    // expected colour table, independent of the design package
    localparam logic [7:0] EXP_PAL [16] = '{
        8'hE3, 8'h00, 8'h10, 8'h39, 8'h02, 8'h2B, 8'h40, 8'h1F,
        8'h60, 8'hE9, 8'h90, 8'hFD, 8'h08, 8'h62, 8'hB6, 8'hFF};

    function automatic logic [15:0][7:0] bench_pal();
        logic [15:0][7:0] p;
        for (int i = 0; i < 16; i++) p[i] = EXP_PAL[i];
        return p;
    endfunction

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] ram_addr;
    logic [7:0]    ram_rdata;
    logic [7:0]    rgb;
    logic          blank;
    logic [7:0]    mem [NBYTES];

    int checks = 0;
    int errors = 0;
    int kcnt   = 0;

    always #10 clk = ~clk;

    always_ff @(posedge clk) ram_rdata <= mem[ram_addr];

    scan_top #(
        .SRC_W(SW), .SRC_H(SH),
        .H_ACTIVE(HA), .H_TOTAL(HT),
        .V_ACTIVE(VA), .V_TOTAL(VT),
        .PALETTE(bench_pal())
    ) u_scan_top (
        .clk(clk), .rst(rst),
        .ram_addr(ram_addr), .ram_rdata(ram_rdata),
        .rgb(rgb), .blank(blank)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit in_window(input int h, input int v);
        return h >= XO && h < XO + 2 * SW && v >= YO && v < YO + 2 * SH;
    endfunction

    function automatic int exp_addr(input int h, input int v);
        return ((v - YO) / 2) * (SW / 2) + (h - XO) / 4;
    endfunction

    function automatic int exp_index(input int h, input int v);
        int sx = (h - XO) / 2;
        int sy = (v - YO) / 2;
        logic [7:0] b = mem[sy * (SW / 2) + sx / 2];
        return (sx % 2 == 0) ? int'(b[7:4]) : int'(b[3:0]);
    endfunction

    task automatic load(input int kind);
        for (int i = 0; i < NBYTES; i++) begin
            case (kind)
                0: mem[i] = {4'(2 + i % 7), 4'(9 + i % 6)};
                1: mem[i] = (i % 2 == 0) ? 8'hF4 : 8'h4F;
                2: mem[i] = {4'(2 * i), 4'(2 * i + 1)};
                3: mem[i] = (i % 2 == 0) ? 8'h0F : 8'hF0;
                default: mem[i] = 8'hFF;
            endcase
        end
    endtask

    // R1: reset holds the outputs dark and blanked, including the first edge after release
    task automatic restart();
        @(negedge clk) rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(blank === 1'b1, "R1", "blank in reset", blank, 1);
            check(rgb === 8'h00, "R1", "rgb in reset", rgb, 0);
        end
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        kcnt = 1;
        check(blank === 1'b1, "R1", "blank after first edge", blank, 1);
        check(rgb === 8'h00, "R1", "rgb after first edge", rgb, 0);
    endtask

    task automatic run(input int frames, input string tag);
        for (int n = 0; n < frames * FRAME; n++) begin
            int p, h, v, q, qh, qv, idx;
            logic [7:0] erg;
            bit eb;
            @(posedge clk);
            @(negedge clk);
            kcnt++;
            // raster counter now at position kcnt: check the address (R4)
            q  = kcnt % FRAME;
            qh = q % HT;
            qv = q / HT;
            if (in_window(qh, qv))
                check(int'(ram_addr) == exp_addr(qh, qv), "R4", "ram_addr",
                      int'(ram_addr), exp_addr(qh, qv));
            // outputs describe position kcnt-2
            p = (kcnt - 2) % FRAME;
            h = p % HT;
            v = p / HT;
            eb  = (h >= HA) || (v >= VA);
            erg = 8'h00;
            if (!eb && in_window(h, v)) begin
                idx = exp_index(h, v);
                erg = (idx == 0) ? 8'h00 : EXP_PAL[idx];
            end
            check(blank === eb, "R2", "blank", blank, eb);
            if (eb)
                check(rgb === erg, "R2", "rgb while blanked", rgb, erg);
            else if (!in_window(h, v))
                check(rgb === erg, "R3", "rgb outside window", rgb, erg);
            else
                check(rgb === erg, tag, "rgb in window", rgb, erg);
        end
    endtask

    task automatic t_nibble_order();   // R5: distinct upper and lower nibbles
        load(0);
        restart();
        run(1, "R5");
    endtask

    task automatic t_doubling();       // R6: alternating source pixels, two frames with wrap
        load(1);
        restart();
        run(2, "R6");
    endtask

    task automatic t_palette();        // R7: every index through the palette
        load(2);
        restart();
        run(1, "R7");
    endtask

    task automatic t_index_zero();     // R8: index 0 next to white, entry 0 overridden
        load(3);
        restart();
        run(1, "R8");
    endtask

    task automatic t_outside();        // R3: full-white picture must not leak outside
        load(4);
        restart();
        run(1, "R3");
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 200000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NBYTES; i++) mem[i] = 8'h00;
        t_nibble_order();
        t_doubling();
        t_palette();
        t_index_zero();
        t_outside();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule